// File: doc/BRIEF.md
# Vector structure load/store decoder

This block classifies 32-bit SIMD structure load/store instruction words. It recognises the instruction class and splits each word into three transfer forms. A multiple-structure form moves whole registers. A single-lane form moves one element of each register. A replicate form loads one element and copies it into every lane.

For each word the decoder reports the following:
- the load/store direction;
- the post-index mode;
- the base register and the first vector register;
- the number of vector registers touched;
- the element size (log2 of the byte count);
- the lane index, for the single-lane form;
- the immediate post-increment byte count.

Any combination that is not a legal encoding raises an unallocated flag, and that flag forces the transfer enable low. The decoder does not generate addresses or access memory. For register-offset post-increment it passes the offset register index through unchanged.

The decode itself is combinational. Its results are registered once, so every output reflects the word presented on the clock edge one cycle earlier. The decoder sits between instruction fetch and a load/store unit, which acts only when the transfer enable is high.

Top module: `vls_decoder`

## Requirements
- R1: A word is handled only when bit 31 is 0 and bits 29:25 equal 00110. A word that is not handled gives handled, unallocated and transfer enable all low.
- R2: Bit 22 gives the load flag (1 = load), bit 23 the post-index flag, bits 9:5 the base register and bits 4:0 the first vector register. The form output is 0 for multiple (bit 24 = 0), 1 for single-lane and 2 for replicate.
- R3: For bit 24 = 1 the register count is {bit13, bit21} + 1, which is 1 to 4. For multiple forms the count follows the type field.
- R4: In a single-structure word with bits 15:14 = 0, the element size is 0 (byte) and the lane is {Q, S, size}. Q is bit 30, S is bit 12 and size is bits 11:10.
- R5: With bits 15:14 = 1, the element size is 1 and the lane is {Q, S, size[1]}. The word is unallocated when size[0] = 1.
- R6: With bits 15:14 = 2, the word is unallocated when size[1] = 1. Otherwise:
  - size[0] = 0 gives element size 2 and lane {Q, S};
  - size[0] = 1 gives element size 3 and lane Q, and the word is unallocated when S = 1.
- R7: Single-structure type values 12 and 14 (bits 15:12) are the replicate form. Their element size is bits 11:10 and their lane is 0, and they are unallocated for stores. Types 13 and 15 are always unallocated.
- R8: A multiple-structure word is unallocated when bit 21 is 1 or the type is not one of 0, 2, 4, 6, 7, 8 or 10. Its element size is bits 11:10.
- R9: With an immediate post-increment, single-lane and replicate words give an increment of register count shifted left by the element size.
- R10: With an immediate post-increment, multiple-structure words give a base byte count that is then doubled when Q = 1. The counts per type are 0→32, 2→32, 4→24, 6→24, 7→8, 8→16 and 10→16. The register count is that base count divided by 8.
- R11: An immediate post-increment is selected when post-index is set and bits 20:16 equal 31. Post-index with any other value is register-offset mode: that index goes out on the offset port and the increment is 0. Post-index clear with bits 20:16 not 0 is unallocated.
- R12: Every output is registered and reflects the word from the previous clock edge. Transfer enable is high exactly when the word is handled and not unallocated. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| handled_o | output | 1 | Word belongs to the structure load/store class |
| unalloc_o | output | 1 | Handled word with an illegal combination |
| xfer_en_o | output | 1 | Legal transfer, act on the other fields |
| form_o | output | 2 | 0 multiple, 1 single-lane, 2 replicate |
| load_o | output | 1 | 1 load, 0 store |
| post_o | output | 1 | Post-index requested |
| post_imm_o | output | 1 | Post-index uses the immediate increment |
| post_rm_o | output | 5 | Offset register index (bits 20:16) |
| base_o | output | 5 | Base register index |
| vreg_o | output | 5 | First vector register index |
| cnt_o | output | 3 | Number of vector registers (1 to 4) |
| esize_o | output | 2 | log2 of element bytes |
| lane_o | output | 4 | Lane index for the single-lane form |
| inc_o | output | 7 | Immediate post-increment in bytes |

## Verification
The bench builds the decoder with its default widths: a 5-bit register index, a 4-bit lane and a 7-bit increment. These widths reach the largest lane (15 for byte lanes with Q and S set) and the largest increment (64 bytes for a four-register multiple transfer with Q set). Directed words walk every unallocated rule. Random words forced mostly into the handled class cover all type, size, S and Q mixes, and each word is compared field by field against a bench model.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam logic [1:0] FORM_MULTI = 2'd0;
  localparam logic [1:0] FORM_LANE  = 2'd1;
  localparam logic [1:0] FORM_REPL  = 2'd2;
  localparam logic [4:0] CLASS_TAG  = 5'b00110;
endpackage

// File: rtl/vls_fields.sv
module vls_fields #(
  parameter int IW = 32,
  parameter int RW = 5
) (
  input  logic [IW-1:0] instr,
  output logic          handled,
  output logic          single,
  output logic          load,
  output logic          post,
  output logic          qbit,
  output logic          b21,
  output logic [3:0]    opc,
  output logic [1:0]    sz,
  output logic [RW-1:0] rm,
  output logic [RW-1:0] base,
  output logic [RW-1:0] vreg,
  output logic          post_imm,
  output logic          post_bad
);
  import vls_pkg::*;
  localparam logic [RW-1:0] RM_IMM = '1;

  always_comb begin
    handled  = (instr[31] == 1'b0) && (instr[29:25] == CLASS_TAG);
    qbit     = instr[30];
    single   = instr[24];
    post     = instr[23];
    load     = instr[22];
    b21      = instr[21];
    rm       = instr[20:16];
    opc      = instr[15:12];
    sz       = instr[11:10];
    base     = instr[9:5];
    vreg     = instr[4:0];
    post_imm = post && (rm == RM_IMM);
    post_bad = !post && (rm != '0);
  end
endmodule

// File: rtl/vls_lane_decode.sv
module vls_lane_decode #(
  parameter int LW = 4
) (
  input  logic [3:0]    opc,
  input  logic [1:0]    sz,
  input  logic          qbit,
  input  logic          load,
  output logic          repl,
  output logic [1:0]    esize,
  output logic [LW-1:0] lane,
  output logic          bad
);
  logic sbit;
  assign sbit = opc[0];

  always_comb begin
    repl  = 1'b0;
    esize = 2'd0;
    lane  = '0;
    bad   = 1'b0;
    case (opc[3:2])
      2'd0: begin
        esize = 2'd0;
        lane  = LW'({qbit, sbit, sz});
      end
      2'd1: begin
        esize = 2'd1;
        lane  = LW'({qbit, sbit, sz[1]});
        bad   = sz[0];
      end
      2'd2: begin
        if (sz[0] == 1'b0) begin
          esize = 2'd2;
          lane  = LW'({qbit, sbit});
        end else begin
          esize = 2'd3;
          lane  = LW'(qbit);
          bad   = sbit;
        end
        if (sz[1]) bad = 1'b1;
      end
      default: begin
        case (opc[1:0])
          2'b00, 2'b10: begin
            repl  = 1'b1;
            esize = sz;
            bad   = !load;
          end
          default: bad = 1'b1;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/vls_multi_decode.sv
module vls_multi_decode #(
  parameter int CW = 3
) (
  input  logic [3:0]    opc,
  input  logic          b21,
  output logic [CW-1:0] cnt,
  output logic          bad
);
  always_comb begin
    cnt = CW'(1);
    bad = b21;
    case (opc)
      4'd0, 4'd2:  cnt = CW'(4);
      4'd4, 4'd6:  cnt = CW'(3);
      4'd8, 4'd10: cnt = CW'(2);
      4'd7:        cnt = CW'(1);
      default:     bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/vls_postinc.sv
module vls_postinc #(
  parameter int CW  = 3,
  parameter int IBW = 7
) (
  input  logic          single,
  input  logic          qbit,
  input  logic          enable,
  input  logic [CW-1:0] cnt,
  input  logic [1:0]    esize,
  output logic [IBW-1:0] inc
);
  logic [2:0] shamt;

  always_comb begin
    shamt = single ? {1'b0, esize} : (3'd3 + {2'b00, qbit});
    inc   = enable ? (IBW'(cnt) << shamt) : '0;
  end
endmodule

// File: rtl/vls_decoder.sv
module vls_decoder #(
  parameter int IW  = 32,
  parameter int RW  = 5,
  parameter int LW  = 4,
  parameter int CW  = 3,
  parameter int IBW = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [IW-1:0]  instr_i,
  output logic           handled_o,
  output logic           unalloc_o,
  output logic           xfer_en_o,
  output logic [1:0]     form_o,
  output logic           load_o,
  output logic           post_o,
  output logic           post_imm_o,
  output logic [RW-1:0]  post_rm_o,
  output logic [RW-1:0]  base_o,
  output logic [RW-1:0]  vreg_o,
  output logic [CW-1:0]  cnt_o,
  output logic [1:0]     esize_o,
  output logic [LW-1:0]  lane_o,
  output logic [IBW-1:0] inc_o
);
  import vls_pkg::*;

  logic          handled_c, single_c, load_c, post_c, qbit_c, b21_c;
  logic [3:0]    opc_c;
  logic [1:0]    sz_c;
  logic [RW-1:0] rm_c, base_c, vreg_c;
  logic          pimm_raw, post_bad_c;

  vls_fields #(.IW(IW), .RW(RW)) u_fields (
    .instr(instr_i), .handled(handled_c), .single(single_c), .load(load_c),
    .post(post_c), .qbit(qbit_c), .b21(b21_c), .opc(opc_c), .sz(sz_c),
    .rm(rm_c), .base(base_c), .vreg(vreg_c), .post_imm(pimm_raw),
    .post_bad(post_bad_c)
  );

  logic          repl_c, lane_bad_c;
  logic [1:0]    lane_esize_c;
  logic [LW-1:0] lane_c;

  vls_lane_decode #(.LW(LW)) u_lane (
    .opc(opc_c), .sz(sz_c), .qbit(qbit_c), .load(load_c),
    .repl(repl_c), .esize(lane_esize_c), .lane(lane_c), .bad(lane_bad_c)
  );

  logic [CW-1:0] multi_cnt_c;
  logic          multi_bad_c;

  vls_multi_decode #(.CW(CW)) u_multi (
    .opc(opc_c), .b21(b21_c), .cnt(multi_cnt_c), .bad(multi_bad_c)
  );

  logic          unalloc_c, xfer_c, pimm_c;
  logic [1:0]    form_c, esize_c;
  logic [CW-1:0] cnt_c;
  logic [LW-1:0] lane_sel_c;
  logic [IBW-1:0] inc_c;

  always_comb begin
    unalloc_c = handled_c &&
                (post_bad_c || (single_c ? lane_bad_c : multi_bad_c));
    xfer_c    = handled_c && !unalloc_c;
    pimm_c    = handled_c && pimm_raw;
    if (!single_c)   form_c = FORM_MULTI;
    else if (repl_c) form_c = FORM_REPL;
    else             form_c = FORM_LANE;
    cnt_c      = single_c ? (CW'({opc_c[1], b21_c}) + CW'(1)) : multi_cnt_c;
    esize_c    = single_c ? lane_esize_c : sz_c;
    lane_sel_c = (single_c && !repl_c) ? lane_c : '0;
  end

  vls_postinc #(.CW(CW), .IBW(IBW)) u_inc (
    .single(single_c), .qbit(qbit_c), .enable(xfer_c && pimm_c),
    .cnt(cnt_c), .esize(esize_c), .inc(inc_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      handled_o  <= 1'b0;
      unalloc_o  <= 1'b0;
      xfer_en_o  <= 1'b0;
      form_o     <= FORM_MULTI;
      load_o     <= 1'b0;
      post_o     <= 1'b0;
      post_imm_o <= 1'b0;
      post_rm_o  <= '0;
      base_o     <= '0;
      vreg_o     <= '0;
      cnt_o      <= '0;
      esize_o    <= '0;
      lane_o     <= '0;
      inc_o      <= '0;
    end else begin
      handled_o  <= handled_c;
      unalloc_o  <= unalloc_c;
      xfer_en_o  <= xfer_c;
      form_o     <= form_c;
      load_o     <= load_c;
      post_o     <= post_c;
      post_imm_o <= pimm_c;
      post_rm_o  <= rm_c;
      base_o     <= base_c;
      vreg_o     <= vreg_c;
      cnt_o      <= cnt_c;
      esize_o    <= esize_c;
      lane_o     <= lane_sel_c;
      inc_o      <= inc_c;
    end
  end

  p_xfer_legal_r12: assert property (@(posedge clk) disable iff (rst)
    xfer_en_o |-> (handled_o && !unalloc_o));
  p_unalloc_class_r1: assert property (@(posedge clk) disable iff (rst)
    unalloc_o |-> handled_o);
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    xfer_en_o |-> (cnt_o >= CW'(1) && cnt_o <= CW'(4)));
  p_lane_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (xfer_en_o && form_o != FORM_LANE) |-> (lane_o == '0));
  p_repl_load_r7: assert property (@(posedge clk) disable iff (rst)
    (xfer_en_o && form_o == FORM_REPL) |-> load_o);
  p_inc_gate_r11: assert property (@(posedge clk) disable iff (rst)
    !post_imm_o |-> (inc_o == '0));
  p_noform_r2: assert property (@(posedge clk) disable iff (rst)
    xfer_en_o |-> (form_o != 2'd3));
endmodule

// File: tb/vls_decoder_tb_top.sv
module vls_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = 32'h0;
  logic        handled, unalloc, xfer, load, post, pimm;
  logic [1:0]  form, esize;
  logic [4:0]  rm, base, vreg;
  logic [2:0]  cnt;
  logic [3:0]  lane;
  logic [6:0]  inc;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vls_decoder dut_i (
    .clk(clk), .rst(rst), .instr_i(instr), .handled_o(handled),
    .unalloc_o(unalloc), .xfer_en_o(xfer), .form_o(form), .load_o(load),
    .post_o(post), .post_imm_o(pimm), .post_rm_o(rm), .base_o(base),
    .vreg_o(vreg), .cnt_o(cnt), .esize_o(esize), .lane_o(lane), .inc_o(inc)
  );

  typedef struct packed {
    logic h, ua, xf;
    logic [1:0] form;
    logic ld, po, pimm;
    logic [4:0] rm, base, vreg;
    logic [2:0] cnt;
    logic [1:0] esz;
    logic [3:0] lane;
    logic [6:0] inc;
  } exp_t;

  function automatic exp_t model(input logic [31:0] w);
    exp_t e;
    logic bad;
    int   c, bytes, incv;
    logic q, s;
    logic [3:0] t;
    logic [1:0] sz;
    e = '0;
    q = w[30]; s = w[12]; t = w[15:12]; sz = w[11:10];
    e.h = (w[31] == 1'b0) && (w[29:25] == 5'b00110);
    e.ld = w[22]; e.po = w[23]; e.rm = w[20:16];
    e.base = w[9:5]; e.vreg = w[4:0];
    bad = (!e.po && e.rm != 5'd0);
    c = 0; incv = 0;
    if (w[24]) begin
      c = {w[13], w[21]} + 1;
      if (t <= 4'd11) begin
        e.form = 2'd1;
        if (t[3:2] == 2'd0) begin e.esz = 2'd0; e.lane = {q, s, sz}; end
        else if (t[3:2] == 2'd1) begin
          e.esz = 2'd1; e.lane = {1'b0, q, s, sz[1]}; if (sz[0]) bad = 1'b1;
        end else begin
          if (sz[1]) bad = 1'b1;
          else if (!sz[0]) begin e.esz = 2'd2; e.lane = {2'b00, q, s}; end
          else begin e.esz = 2'd3; e.lane = {3'b000, q}; if (s) bad = 1'b1; end
        end
      end else if (t == 4'd12 || t == 4'd14) begin
        e.form = 2'd2; e.esz = sz; if (!e.ld) bad = 1'b1;
      end else bad = 1'b1;
      incv = c * (1 << e.esz);
    end else begin
      e.form = 2'd0; e.esz = sz;
      if (w[21]) bad = 1'b1;
      case (t)
        4'd0, 4'd2: bytes = 32;
        4'd4, 4'd6: bytes = 24;
        4'd8, 4'd10: bytes = 16;
        4'd7: bytes = 8;
        default: begin bytes = 8; bad = 1'b1; end
      endcase
      c = bytes / 8;
      incv = q ? bytes * 2 : bytes;
    end
    e.cnt  = 3'(c);
    e.pimm = e.h && e.po && (e.rm == 5'd31);
    e.ua   = e.h && bad;
    e.xf   = e.h && !bad;
    e.inc  = (e.xf && e.pimm) ? 7'(incv) : 7'd0;
    return e;
  endfunction

  function automatic logic [31:0] mk(input logic q, input logic single,
      input logic post, input logic ld, input logic b21, input logic [4:0] r,
      input logic [3:0] t, input logic [1:0] sz);
    return {1'b0, q, 5'b00110, single, post, ld, b21, r, t, sz, 5'd3, 5'd9};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (instr=%08h)", tag, act, exp, instr);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    instr = w;
    @(negedge clk);
  endtask

  task automatic full_check(input logic [31:0] w, input string tag);
    exp_t e;
    e = model(w);
    apply(w);
    chk({tag, " R1 handled"}, 32'(handled), 32'(e.h));
    chk({tag, " R12 unalloc"}, 32'(unalloc), 32'(e.ua));
    chk({tag, " R12 xfer"}, 32'(xfer), 32'(e.xf));
    chk({tag, " R11 post_imm"}, 32'(pimm), 32'(e.pimm));
    chk({tag, " R9 inc"}, 32'(inc), 32'(e.inc));
    if (e.xf) begin
      chk({tag, " R2 form"}, 32'(form), 32'(e.form));
      chk({tag, " R2 load"}, 32'(load), 32'(e.ld));
      chk({tag, " R2 post"}, 32'(post), 32'(e.po));
      chk({tag, " R2 base"}, 32'(base), 32'(e.base));
      chk({tag, " R2 vreg"}, 32'(vreg), 32'(e.vreg));
      chk({tag, " R11 rm"}, 32'(rm), 32'(e.rm));
      chk({tag, " R3 cnt"}, 32'(cnt), 32'(e.cnt));
      chk({tag, " R6 esize"}, 32'(esize), 32'(e.esz));
      chk({tag, " R4 lane"}, 32'(lane), 32'(e.lane));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset xfer", 32'(xfer), 32'd0);
    chk("R12 reset handled", 32'(handled), 32'd0);
    chk("R12 reset unalloc", 32'(unalloc), 32'd0);
    rst = 1'b0;

    // R4: byte lane, Q=1 S=1 size=3 -> lane 15, count 1
    apply(mk(1, 1, 0, 1, 0, 5'd0, 4'b0001, 2'd3));
    chk("R4 byte lane", 32'(lane), 32'd15);
    chk("R4 byte esize", 32'(esize), 32'd0);
    chk("R3 count one", 32'(cnt), 32'd1);
    // R5
    apply(mk(0, 1, 0, 1, 0, 5'd0, 4'b0100, 2'b01));
    chk("R5 half size0 unalloc", 32'(unalloc), 32'd1);
    chk("R5 half size0 xfer", 32'(xfer), 32'd0);
    apply(mk(1, 1, 0, 1, 0, 5'd0, 4'b0101, 2'b10));
    chk("R5 half lane", 32'(lane), 32'd7);
    chk("R5 half esize", 32'(esize), 32'd1);
    // R6
    apply(mk(1, 1, 0, 0, 0, 5'd0, 4'b1001, 2'b00));
    chk("R6 word lane", 32'(lane), 32'd3);
    chk("R6 word esize", 32'(esize), 32'd2);
    apply(mk(1, 1, 0, 1, 0, 5'd0, 4'b1000, 2'b01));
    chk("R6 dword lane", 32'(lane), 32'd1);
    chk("R6 dword esize", 32'(esize), 32'd3);
    apply(mk(0, 1, 0, 1, 0, 5'd0, 4'b1001, 2'b01));
    chk("R6 dword S unalloc", 32'(unalloc), 32'd1);
    apply(mk(0, 1, 0, 1, 0, 5'd0, 4'b1000, 2'b10));
    chk("R6 size1 unalloc", 32'(unalloc), 32'd1);
    // R7 / R9
    apply(mk(0, 1, 1, 1, 1, 5'd31, 4'b1110, 2'd3));
    chk("R7 repl form", 32'(form), 32'd2);
    chk("R7 repl count", 32'(cnt), 32'd4);
    chk("R7 repl esize", 32'(esize), 32'd3);
    chk("R9 repl inc", 32'(inc), 32'd32);
    apply(mk(0, 1, 0, 0, 0, 5'd0, 4'b1100, 2'd0));
    chk("R7 repl store unalloc", 32'(unalloc), 32'd1);
    apply(mk(0, 1, 0, 1, 0, 5'd0, 4'b1101, 2'd0));
    chk("R7 type13 unalloc", 32'(unalloc), 32'd1);
    // R9 / R3: lane store, count 4, bytes
    apply(mk(0, 1, 1, 0, 1, 5'd31, 4'b0010, 2'd0));
    chk("R3 count four", 32'(cnt), 32'd4);
    chk("R9 lane inc", 32'(inc), 32'd4);
    // R8
    apply(mk(0, 0, 0, 1, 1, 5'd0, 4'd0, 2'd0));
    chk("R8 b21 unalloc", 32'(unalloc), 32'd1);
    apply(mk(0, 0, 0, 1, 0, 5'd0, 4'd1, 2'd0));
    chk("R8 type1 unalloc", 32'(unalloc), 32'd1);
    // R10
    apply(mk(1, 0, 1, 1, 0, 5'd31, 4'd0, 2'd2));
    chk("R10 type0 Q inc", 32'(inc), 32'd64);
    chk("R10 type0 count", 32'(cnt), 32'd4);
    chk("R8 multi esize", 32'(esize), 32'd2);
    apply(mk(0, 0, 1, 0, 0, 5'd31, 4'd7, 2'd0));
    chk("R10 type7 inc", 32'(inc), 32'd8);
    chk("R10 type7 count", 32'(cnt), 32'd1);
    // R11
    apply(mk(0, 1, 1, 1, 0, 5'd5, 4'b0000, 2'd0));
    chk("R11 reg offset imm", 32'(pimm), 32'd0);
    chk("R11 reg offset rm", 32'(rm), 32'd5);
    chk("R11 reg offset inc", 32'(inc), 32'd0);
    chk("R11 reg offset xfer", 32'(xfer), 32'd1);
    apply(mk(0, 1, 0, 1, 0, 5'd3, 4'b0000, 2'd0));
    chk("R11 nonpost rm unalloc", 32'(unalloc), 32'd1);
    // R1
    apply(mk(0, 1, 0, 1, 0, 5'd0, 4'b0000, 2'd0) | 32'h8000_0000);
    chk("R1 not handled", 32'(handled), 32'd0);
    chk("R1 not handled xfer", 32'(xfer), 32'd0);
    chk("R1 not handled unalloc", 32'(unalloc), 32'd0);
    // R2 field check
    full_check(mk(1, 0, 0, 0, 0, 5'd0, 4'd10, 2'd1), "R2 directed");

    void'($urandom(32'd2024));
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] w;
      logic [2:0]  pick;
      w = $urandom();
      if (($urandom() % 8) != 0) begin
        w[31] = 1'b0;
        w[29:25] = 5'b00110;
      end
      pick = 3'($urandom() % 4);
      if (pick == 3'd0) w[20:16] = 5'd0;
      else if (pick == 3'd1) begin w[20:16] = 5'd31; w[23] = 1'b1; end
      else if (pick == 3'd2) w[23] = 1'b0;
      full_check(w, "rand");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule